// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is a hardware evaluation stack for postfix expressions. Only the topmost `N` entries are kept in flip-flops, called the register window. Deeper entries move out to a simple synchronous memory port. Commands arrive one at a time on a valid/ready handshake. A command can push an operand, pop the top entry, or apply one of four binary operators: add, subtract, multiply or divide. An operator consumes the two topmost entries and leaves its result on top. The current top of stack and the total depth are always visible on the outputs.

The block generates all memory traffic by itself, and only at the edges of the window:

- A push onto a full window first writes the deepest register entry to memory. This is a spill.
- A pop or an operator that leaves the window one entry short reads the most recently spilled entry back. This is a fill.

Spilled entries grow upward from a base address, tracked by a memory pointer that is separate from the window occupancy. Two counters record the number of spills and fills. Three sticky flags report:

- underflow (too few entries for a command),
- overflow (the spill region is exhausted),
- division by zero.

Back-pressure rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while a fill is in flight. A source that raises `cmd_valid` while `cmd_ready` is low must hold the command stable. That command is taken exactly once, on the first edge where `cmd_ready` is high. The memory port has no handshake. A write completes in the cycle it is requested. Read data is expected on `mem_rdata` in the cycle after the read request.

Top module: `evstk_core`

## Requirements
- R1: A push (opcode 0) places `cmd_operand` on `tos` and raises `depth` by one, visible after the accepting edge.
- R2: A pop (opcode 1) removes the top entry, so the entry beneath becomes `tos` and `depth` drops by one. Entries come back in last-in-first-out order, and `tos` reads zero when the stack is empty.
- R3: Opcodes 2 (add), 3 (subtract), 4 (multiply) and 5 (divide) combine the entry below the top (left operand) with the top (right operand). They replace both entries with the 16-bit wrapped result. Division is signed and truncates toward zero.
- R4: A memory write is issued only when a push meets a full window. The write carries the deepest window entry to address base plus the count of entries already in memory, in the accepting cycle.
- R5: When a pop or operator is accepted while memory holds entries, one read is issued at base plus that count minus one in the next cycle. The data is taken into the window the cycle after that. `cmd_ready` stays low for exactly those two cycles.
- R6: `spill_count` and `fill_count` count memory writes and reads. With a two-entry window, the sequence a b c * + a d c * + e - / yields 4 of each.
- R7: A pop on an empty stack, or an operator on fewer than two entries, sets `err_underflow` (which stays set) and leaves the stack unchanged.
- R8: A push when the stack already holds `N + MEM_DEPTH` entries sets `err_overflow` (which stays set), writes no memory and leaves the stack unchanged.
- R9: A divide with a zero top entry produces 0xFFFF and sets `err_divzero`, which stays set.
- R10: Opcodes 6 and 7 are accepted and change nothing. A command held valid while `cmd_ready` is low is executed exactly once.
- R11: After reset, `tos` is 0, `depth` is 0, `cmd_ready` is 1, and all counters, flags and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div) |
| cmd_operand | input | W | Value for a push |
| tos | output | W | Current top entry |
| depth | output | DW | Total entries in window and memory |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write (spill), 0 read (fill) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | W | Spill data |
| mem_rdata | input | W | Fill data, valid the cycle after a read |
| spill_count | output | CNTW | Spills performed |
| fill_count | output | CNTW | Fills performed |
| err_underflow | output | 1 | Sticky underflow flag |
| err_overflow | output | 1 | Sticky spill-region overflow flag |
| err_divzero | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench builds the block with a two-entry window, eight spill slots and a base address of 32. The narrow window makes the postfix example spill and fill exactly four times each. The small spill region lets ten pushes reach the overflow limit, so the refused eleventh push can be observed. A push held valid during a fill shows that a stalled command is taken only once. Every memory address is predicted from a reference stack and compared.

// File: rtl/evstk_pkg.sv
`timescale 1ns/1ps
package evstk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } evstk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_RD   = 2'd1,
    ST_FILL_WAIT = 2'd2
  } evstk_state_e;
endpackage

// File: rtl/evstk_alu.sv
`timescale 1ns/1ps
module evstk_alu
  import evstk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output logic         div_zero
);
  logic [2*W-1:0]      prod;
  logic signed [W-1:0] quot;

  always_comb begin
    prod     = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};
    quot     = $signed(lhs) / $signed(rhs);
    div_zero = 1'b0;
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = prod[W-1:0];
      OP_DIV: begin
        div_zero = (rhs == '0);
        res      = div_zero ? {W{1'b1}} : quot;
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/evstk_regwin.sv
`timescale 1ns/1ps
module evstk_regwin #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [W-1:0]  push_val,
  input  logic          shrink_en,
  input  logic          top_we,
  input  logic [W-1:0]  top_val,
  input  logic          fill_en,
  input  logic [W-1:0]  fill_val,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  top,
  output logic [W-1:0]  second,
  output logic [W-1:0]  bottom
);
  logic [W-1:0] ent [N];
  logic [W-1:0] nxt [N];

  // index 0 is the top; entries at or beyond cnt are kept at zero
  always_comb begin
    for (int i = 0; i < N; i++) begin
      nxt[i] = ent[i];
      if (push_en) begin
        nxt[i] = (i == 0) ? push_val : ent[(i == 0) ? 0 : i - 1];
      end else if (shrink_en) begin
        if (i == 0 && top_we) nxt[i] = top_val;
        else                  nxt[i] = (i == N - 1) ? '0 : ent[(i == N - 1) ? i : i + 1];
      end else if (fill_en && cnt == CW'(i)) begin
        nxt[i] = fill_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;
      cnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) ent[i] <= nxt[i];
      if (push_en && cnt != CW'(N)) cnt <= cnt + CW'(1);
      else if (shrink_en)           cnt <= cnt - CW'(1);
      else if (fill_en)             cnt <= cnt + CW'(1);
    end
  end

  assign top    = ent[0];
  assign second = ent[1];
  assign bottom = ent[N-1];

  AST_WIN_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && (push_en || shrink_en))) else $error("window got two actions"); // R10
  AST_WIN_NO_EMPTY_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_en |-> cnt != '0) else $error("shrink of empty window"); // R7
  AST_WIN_FILL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> cnt < CW'(N)) else $error("fill into full window"); // R5
endmodule

// File: rtl/evstk_core.sv
`timescale 1ns/1ps
module evstk_core
  import evstk_pkg::*;
#(
  parameter int W         = 16,
  parameter int N         = 4,
  parameter int MEM_DEPTH = 64,
  parameter int AW        = 10,
  parameter int MEM_BASE  = 0,
  parameter int CNTW      = 16,
  localparam int DW       = $clog2(N + MEM_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [W-1:0]    cmd_operand,
  output logic [W-1:0]    tos,
  output logic [DW-1:0]   depth,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic [CNTW-1:0] spill_count,
  output logic [CNTW-1:0] fill_count,
  output logic            err_underflow,
  output logic            err_overflow,
  output logic            err_divzero
);
  localparam int CW        = $clog2(N + 1);
  localparam int MW        = $clog2(MEM_DEPTH + 1);
  localparam int DEPTH_MAX = N + MEM_DEPTH;

  evstk_state_e  state;
  logic [CW-1:0] win_cnt;
  logic [W-1:0]  win_top, win_second, win_bottom, alu_res;
  logic [MW-1:0] msp;
  logic [DW-1:0] total;
  logic accept, is_push, is_pop, is_bin, full, under;
  logic push_ok, spill, shrink_ok, fill_en, alu_dz;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign is_push   = (cmd_op == OP_PUSH);
  assign is_pop    = (cmd_op == OP_POP);
  assign is_bin    = (cmd_op >= OP_ADD) && (cmd_op <= OP_DIV);
  assign total     = DW'(win_cnt) + DW'(msp);
  assign full      = (total == DW'(DEPTH_MAX));
  assign under     = (is_pop && total == '0) || (is_bin && total < DW'(2));
  assign push_ok   = accept && is_push && !full;
  assign spill     = push_ok && (win_cnt == CW'(N));
  assign shrink_ok = accept && (is_pop || is_bin) && !under;
  assign fill_en   = (state == ST_FILL_WAIT);

  evstk_alu #(.W(W)) u_alu (
    .op       (cmd_op),
    .lhs      (win_second),
    .rhs      (win_top),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  evstk_regwin #(.W(W), .N(N)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ok),
    .push_val  (cmd_operand),
    .shrink_en (shrink_ok),
    .top_we    (is_bin),
    .top_val   (alu_res),
    .fill_en   (fill_en),
    .fill_val  (mem_rdata),
    .cnt       (win_cnt),
    .top       (win_top),
    .second    (win_second),
    .bottom    (win_bottom)
  );

  assign mem_req   = spill || (state == ST_FILL_RD);
  assign mem_we    = spill;
  assign mem_wdata = win_bottom;
  assign mem_addr  = AW'(MEM_BASE) + (spill ? AW'(msp) : AW'(msp) - AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (shrink_ok && msp != '0) state <= ST_FILL_RD;
        ST_FILL_RD: state <= ST_FILL_WAIT;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp           <= '0;
      spill_count   <= '0;
      fill_count    <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_divzero   <= 1'b0;
    end else begin
      if (spill) begin
        msp         <= msp + MW'(1);
        spill_count <= spill_count + CNTW'(1);
      end else if (fill_en) begin
        msp        <= msp - MW'(1);
        fill_count <= fill_count + CNTW'(1);
      end
      if (accept && under)                 err_underflow <= 1'b1;
      if (accept && is_push && full)       err_overflow  <= 1'b1;
      if (shrink_ok && is_bin && alu_dz)   err_divzero   <= 1'b1;
    end
  end

  assign tos   = win_top;
  assign depth = total;

  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (!cmd_ready && !mem_req)) else $error("fill timing"); // R5
  AST_SPILL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (win_cnt == CW'(N))) else $error("spill from partial window"); // R4
  AST_WINDOW_TOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && msp != '0) |-> (win_cnt == CW'(N))) else $error("window short while idle"); // R5
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH_MAX)) else $error("depth beyond limit"); // R8
  AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_push && depth == DW'(DEPTH_MAX)) |-> !mem_req) else $error("write on overflow"); // R8
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow) else $error("underflow flag cleared"); // R7
  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_pop && depth == '0) |=> (depth == '0)) else $error("empty pop changed depth"); // R7
  AST_DIVZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_divzero |=> err_divzero) else $error("divzero flag cleared"); // R9
endmodule

// File: tb/evstk_core_bench.sv
`timescale 1ns/1ps
module evstk_core_bench;
  localparam int W = 16, N = 2, MD = 8, AW = 8, BASE = 32;
  localparam int DW = $clog2(N + MD + 1);
  localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, ADD = 3'd2, SUB = 3'd3,
                         MUL = 3'd4, DIV = 3'd5, NOP6 = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [W-1:0] cmd_operand = '0, tos, mem_wdata, mem_rdata = '0;
  logic [DW-1:0] depth;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] spill_count, fill_count;
  logic err_underflow, err_overflow, err_divzero;
  logic [W-1:0] mem [256];

  evstk_core #(.W(W), .N(N), .MEM_DEPTH(MD), .AW(AW), .MEM_BASE(BASE), .CNTW(16)) u_evstk_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_operand(cmd_operand), .tos(tos), .depth(depth),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .spill_count(spill_count), .fill_count(fill_count),
    .err_underflow(err_underflow), .err_overflow(err_overflow), .err_divzero(err_divzero)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else        mem_rdata     <= mem[mem_addr];
  end

  typedef struct {
    int tos; int depth; int sp; int fl; int uf; int of; int dz; int lat; string tag;
  } exp_t;

  exp_t exp_q[$];
  int addr_q[$];
  logic [15:0] stk[$];
  int m_sp = 0, m_fl = 0, m_uf = 0, m_of = 0, m_dz = 0;
  int n_chk = 0, n_fail = 0, lowcnt = 0;
  bit pend = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // scoreboard monitor: compares once the design is ready after a command
  always @(negedge clk) begin
    if (pend && !cmd_ready) lowcnt++;
    else if (pend && cmd_ready && !cmd_valid) begin
      exp_t e;
      e = exp_q[$];
      exp_q.delete();
      chk(e.tag, "tos", int'(tos), e.tos);
      chk(e.tag, "depth", int'(depth), e.depth);
      chk(e.tag, "spill_count", int'(spill_count), e.sp);
      chk(e.tag, "fill_count", int'(fill_count), e.fl);
      chk(e.tag, "err_underflow", int'(err_underflow), e.uf);
      chk(e.tag, "err_overflow", int'(err_overflow), e.of);
      chk(e.tag, "err_divzero", int'(err_divzero), e.dz);
      if (e.lat >= 0) chk(e.tag, "R5 ready-low cycles", lowcnt, e.lat);
      lowcnt = 0;
      pend = 0;
    end
  end

  // memory-port monitor: every access must have been predicted in order
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_req) begin
      if (addr_q.size() == 0) chk("R4", "unexpected memory access", 1, 0);
      else begin
        int a;
        a = addr_q.pop_front();
        chk("R4 R5", "memory address", int'(mem_addr), a);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [15:0] v, input string tag, input bit eager = 0);
    int tot;
    int fill;
    logic [15:0] a, b, r;
    exp_t e;
    bit rdy;
    if (!eager) wait (pend == 0);
    @(negedge clk);
    tot = stk.size();
    fill = 0;
    case (op)
      PUSH: if (tot == N + MD) m_of = 1;
            else begin
              if (tot >= N) begin addr_q.push_back(BASE + tot - N); m_sp++; end
              stk.push_back(v);
            end
      POP:  if (tot == 0) m_uf = 1;
            else begin
              void'(stk.pop_back());
              if (tot > N) begin addr_q.push_back(BASE + tot - N - 1); m_fl++; fill = 1; end
            end
      ADD, SUB, MUL, DIV:
            if (tot < 2) m_uf = 1;
            else begin
              b = stk.pop_back();
              a = stk.pop_back();
              case (op)
                ADD: r = a + b;
                SUB: r = a - b;
                MUL: r = a * b;
                default: begin
                  if (b == 0) begin r = 16'hFFFF; m_dz = 1; end
                  else r = 16'($signed(a) / $signed(b));
                end
              endcase
              stk.push_back(r);
              if (tot > N) begin addr_q.push_back(BASE + tot - N - 1); m_fl++; fill = 1; end
            end
      default: ;
    endcase
    e.tos = (stk.size() > 0) ? int'(stk[$]) : 0;
    e.depth = stk.size();
    e.sp = m_sp; e.fl = m_fl; e.uf = m_uf; e.of = m_of; e.dz = m_dz;
    e.lat = eager ? -1 : (fill ? 2 : 0);
    e.tag = tag;
    cmd_valid = 1'b1; cmd_op = op; cmd_operand = v;
    do begin
      rdy = cmd_ready;
      @(posedge clk);
    end while (!rdy);
    #1 cmd_valid = 1'b0;
    exp_q.push_back(e);
    pend = 1;
  endtask

  initial begin
    #(4 * 150000);
    chk("WATCHDOG", "run completed", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "tos", int'(tos), 0);
    chk("R11", "depth", int'(depth), 0);
    chk("R11", "cmd_ready", int'(cmd_ready), 1);
    chk("R11", "flags", int'({err_underflow, err_overflow, err_divzero, mem_req}), 0);
    chk("R11", "counters", int'(spill_count) + int'(fill_count), 0);
    rst_n = 1'b1;

    // postfix example a b c * + a d c * + e - / with a=7 b=3 c=5 d=2 e=4
    issue(PUSH, 7, "R1"); issue(PUSH, 3, "R1"); issue(PUSH, 5, "R1 R4");
    issue(MUL, 0, "R3 R5"); issue(ADD, 0, "R3");
    issue(PUSH, 7, "R1"); issue(PUSH, 2, "R4"); issue(PUSH, 5, "R4");
    issue(MUL, 0, "R3 R5"); issue(ADD, 0, "R3 R5");
    issue(PUSH, 4, "R4"); issue(SUB, 0, "R3 R5"); issue(DIV, 0, "R3 R6");
    wait (pend == 0);
    chk("R6", "postfix spills", int'(spill_count), 4);
    chk("R6", "postfix fills", int'(fill_count), 4);
    chk("R6", "postfix value", int'(tos), 1);

    issue(POP, 0, "R2");
    issue(POP, 0, "R7 empty pop");
    issue(PUSH, 5, "R1");
    issue(ADD, 0, "R7 single-entry add");
    issue(POP, 0, "R2");

    issue(PUSH, 16'h7FFF, "R1"); issue(PUSH, 1, "R1"); issue(ADD, 0, "R3 add wrap");
    issue(PUSH, 3, "R1"); issue(SUB, 0, "R3 sub");
    issue(PUSH, 16'h0100, "R1"); issue(MUL, 0, "R3 mul wrap");
    issue(PUSH, 0, "R1"); issue(DIV, 0, "R9 divide by zero");
    issue(POP, 0, "R2");
    issue(PUSH, 16'hFFF9, "R1"); issue(PUSH, 2, "R1"); issue(DIV, 0, "R3 signed div");
    issue(POP, 0, "R2");

    for (int i = 1; i <= N + MD; i++) issue(PUSH, 16'(i), "R4 deep push");
    issue(PUSH, 11, "R8 overflow push");
    issue(NOP6, 16'h55, "R10 undefined opcode");
    issue(POP, 0, "R5 fill after pop");
    issue(PUSH, 77, "R10 held during fill", 1);
    for (int i = 0; i < N + MD; i++) issue(POP, 0, "R2 lifo drain");
    issue(POP, 0, "R7 pop after drain");
    wait (pend == 0);
    repeat (2) @(negedge clk);
    chk("R4", "predicted accesses left", addr_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule